// File: doc/BRIEF.md
# Ping-Pong Stream Receive Buffer with Software-Released Back-Pressure

This block sits at the end of a one-way, high-rate data stream that carries words from an upstream sender toward a host. Incoming words are written into one of two equal receive buffers in turn. A buffer is closed when it reaches its capacity or when the sender tags a word as the end of a batch. The host reads a closed buffer through a simple registered read port, for example from a DMA engine, and then hands the buffer back by pulsing a release bit.

When both buffers are closed and not yet handed back, the block raises a wait line toward the sender. Wait rises on the clock edge that stores the word filling the second buffer. It stays high until software releases the oldest buffer. The sender may still push up to two words after it sees wait. These words are held in a small skid store and are written into the freed buffer before wait drops. A level interrupt stays high while any buffer is closed and not released. Buffers must be released in the order in which they were filled.

Top module: `stream_rx_buffer`

## Requirements
- R1: A word stored at index i of buffer b is returned on `host_rdata` one clock after `host_raddr` = {b, i} is presented. Bit 8 of the address selects the buffer and bits 7:0 select the word.
- R2: The first batch after reset goes into buffer 0. Later batches alternate between buffer 1 and buffer 0, and each batch starts at index 0.
- R3: A buffer closes (its `buf_full` bit becomes 1) on the edge that stores its 256th word, or on the edge that stores a word with `s_last` = 1. Its word count is shown on `buf_count` (buffer 0 in bits 8:0, buffer 1 in bits 17:9) and lies between 1 and 256 while it is closed.
- R4: `s_wait` rises on the same edge that closes the second buffer, and stays high for as long as both buffers are closed.
- R5: Up to two words that arrive while `s_wait` is high are kept in arrival order. After a release, they are written into the freed buffer, one per cycle. `s_wait` drops on the edge that writes the last of them.
- R6: A `host_release` pulse is accepted only for the oldest closed buffer. An accepted pulse clears that buffer's full bit and sets its count to 0. A pulse for a buffer that is not closed, or for the newer of two closed buffers, changes nothing.
- R7: `irq` is high exactly while at least one buffer is closed and not released.
- R8: After a synchronous reset, `s_wait`, `irq`, `buf_full` and `buf_count` are all 0.
- R9: The count and the contents of a closed buffer do not change until that buffer is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Stream word present this cycle |
| s_data | input | 32 | Stream word |
| s_last | input | 1 | Word ends the current batch |
| s_wait | output | 1 | Back-pressure toward the sender |
| host_raddr | input | 9 | Host read address {buffer, index} |
| host_rdata | output | 32 | Read data, one cycle after the address |
| host_release | input | 2 | Per-buffer release pulse from software |
| buf_full | output | 2 | Buffer closed and awaiting release |
| buf_count | output | 18 | Latched word counts, 9 bits per buffer |
| irq | output | 1 | Level interrupt: some buffer awaits release |

## Verification
If the fill pointer or the release pointer goes wrong, data shows up in the wrong buffer. A release is then accepted or ignored against the required order, and this is visible at the next read-back or at the `buf_full` value one cycle after the pulse. A bad count or a bad close test shows up at once as a wrong `buf_count`. It also moves the edge at which `buf_full` and `s_wait` rise away from the write of the 256th or the tagged word. A skid store that loses or reorders words, or lets `s_wait` drop early, is caught within three cycles of the release by the `s_wait` sequence, and later by the read-back of the freed buffer.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int NBUF = 2;
  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} buf_id_e;
endpackage

// File: rtl/srb_skid.sv
module srb_skid #(
  parameter int W     = 33,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  assign dout = slots[rp];
endmodule

// File: rtl/srb_ram.sv
module srb_ram #(
  parameter int DW = 32,
  parameter int AW = 9,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int SKID  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SCW  = $clog2(SKID + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_last,
  input  logic                     skid_last,
  input  logic [SCW-1:0]           skid_cnt,
  input  logic [NBUF-1:0]          host_rel,
  output logic                     wr_en,
  output logic [AW:0]              wr_addr,
  output logic                     from_skid,
  output logic                     push,
  output logic                     pop,
  output logic [NBUF-1:0]          full,
  output logic [NBUF-1:0][CW-1:0]  cnt,
  output logic                     wait_q,
  output logic                     irq_q
);
  buf_id_e         fill_ptr, rel_ptr;
  logic            skid_any, avail, wr_last, close, rel_ok, room;
  logic [NBUF-1:0] full_nx;
  logic [SCW-1:0]  skid_nx;

  always_comb begin
    skid_any  = (skid_cnt != '0);
    avail     = !full[fill_ptr];
    from_skid = skid_any;
    wr_en     = avail && (skid_any || in_valid);
    pop       = avail && skid_any;
    room      = (skid_cnt < SCW'(SKID)) || pop;
    push      = in_valid && (skid_any || !avail) && room;
    wr_last   = skid_any ? skid_last : in_last;
    close     = wr_en && (wr_last || cnt[fill_ptr] == CW'(DEPTH - 1));
    rel_ok    = host_rel[rel_ptr] && full[rel_ptr];
    wr_addr   = {fill_ptr, cnt[fill_ptr][AW-1:0]};
    full_nx   = full;
    if (rel_ok) full_nx[rel_ptr]  = 1'b0;
    if (close)  full_nx[fill_ptr] = 1'b1;
    skid_nx   = skid_cnt + SCW'(push) - SCW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= '0;
      cnt      <= '0;
      fill_ptr <= BUF_A;
      rel_ptr  <= BUF_A;
      wait_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      full <= full_nx;
      if (rel_ok) begin
        cnt[rel_ptr] <= '0;
        rel_ptr      <= buf_id_e'(~rel_ptr);
      end
      if (wr_en) cnt[fill_ptr] <= cnt[fill_ptr] + 1'b1;
      if (close) fill_ptr <= buf_id_e'(~fill_ptr);
      wait_q <= (&full_nx) || (skid_nx != '0);
      irq_q  <= |full_nx;
    end
  end
endmodule

// File: rtl/stream_rx_buffer.sv
module stream_rx_buffer
  import srb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  parameter int SKID  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SCW  = $clog2(SKID + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  input  logic [DW-1:0]      s_data,
  input  logic               s_last,
  output logic               s_wait,
  input  logic [AW:0]        host_raddr,
  output logic [DW-1:0]      host_rdata,
  input  logic [NBUF-1:0]    host_release,
  output logic [NBUF-1:0]    buf_full,
  output logic [NBUF*CW-1:0] buf_count,
  output logic               irq
);
  logic                    wr_en, from_skid, push, pop;
  logic [AW:0]             wr_addr;
  logic [DW:0]             skid_out, in_word, wr_word;
  logic [SCW-1:0]          skid_cnt;
  logic [NBUF-1:0][CW-1:0] cnt;

  assign in_word = {s_last, s_data};
  assign wr_word = from_skid ? skid_out : in_word;

  srb_skid #(.W(DW + 1), .DEPTH(SKID)) u_skid (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .din(in_word), .dout(skid_out), .count(skid_cnt)
  );

  srb_ctrl #(.DEPTH(DEPTH), .SKID(SKID)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(s_valid), .in_last(s_last),
    .skid_last(skid_out[DW]), .skid_cnt(skid_cnt), .host_rel(host_release),
    .wr_en(wr_en), .wr_addr(wr_addr), .from_skid(from_skid),
    .push(push), .pop(pop), .full(buf_full), .cnt(cnt),
    .wait_q(s_wait), .irq_q(irq)
  );

  srb_ram #(.DW(DW), .AW(AW + 1)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_word[DW-1:0]),
    .raddr(host_raddr), .rdata(host_rdata)
  );

  assign buf_count = cnt;
endmodule

// File: rtl/stream_rx_buffer_chk.sv
module stream_rx_buffer_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            s_wait,
  input logic            irq,
  input logic [1:0]      buf_full,
  input logic [2*CW-1:0] buf_count,
  input logic [1:0]      host_release
);
  assert_wait_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    (&buf_full) |-> s_wait);

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|buf_full));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (buf_count[CW-1:0] <= CW'(DEPTH)) && (buf_count[2*CW-1:CW] <= CW'(DEPTH)));

  assert_full_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (buf_full[0] |-> buf_count[CW-1:0] != '0) and
    (buf_full[1] |-> buf_count[2*CW-1:CW] != '0));

  assert_hold_buf0_R9: assert property (@(posedge clk) disable iff (rst)
    buf_full[0] && !host_release[0] |=> buf_full[0] && $stable(buf_count[CW-1:0]));

  assert_hold_buf1_R9: assert property (@(posedge clk) disable iff (rst)
    buf_full[1] && !host_release[1] |=> buf_full[1] && $stable(buf_count[2*CW-1:CW]));
endmodule

bind stream_rx_buffer stream_rx_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .s_wait(s_wait), .irq(irq), .buf_full(buf_full),
  .buf_count(buf_count), .host_release(host_release)
);

// File: tb/test_stream_rx_buffer.sv
`timescale 1ns/1ps
module test_stream_rx_buffer;
  localparam int DW = 32, DEPTH = 256, AW = 8, CW = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst, s_valid, s_last, s_wait, irq;
  logic [DW-1:0]   s_data, host_rdata;
  logic [AW:0]     host_raddr;
  logic [1:0]      host_release, buf_full;
  logic [2*CW-1:0] buf_count;

  stream_rx_buffer i_stream_rx_buffer (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_wait(s_wait), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .host_release(host_release), .buf_full(buf_full), .buf_count(buf_count),
    .irq(irq)
  );

  int vectors = 0, misses = 0;
  logic [DW-1:0] exp_mem [2][DEPTH];
  logic mfull [2];
  int   mcnt  [2];
  int   mfill, mrel;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void mput(logic [DW-1:0] d, logic l);
    exp_mem[mfill][mcnt[mfill]] = d;
    mcnt[mfill]++;
    if (l || mcnt[mfill] == DEPTH) begin
      mfull[mfill] = 1'b1;
      mfill ^= 1;
    end
  endfunction

  task automatic check_state(string req);
    chk(req, "buf_full", 64'(buf_full), 64'({mfull[1], mfull[0]}));
    chk(req, "count0", 64'(buf_count[CW-1:0]), 64'(mcnt[0]));
    chk(req, "count1", 64'(buf_count[2*CW-1:CW]), 64'(mcnt[1]));
    chk(req, "irq R7", 64'(irq), 64'(mfull[0] | mfull[1]));
    chk(req, "s_wait R4", 64'(s_wait), 64'(mfull[0] & mfull[1]));
  endtask

  task automatic send(logic [DW-1:0] d, logic l);
    s_valid = 1'b1; s_data = d; s_last = l;
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    mput(d, l);
  endtask

  task automatic rel(int b);
    host_release = 2'(1 << b);
    @(negedge clk);
    host_release = '0;
    if (mfull[b] && b == mrel) begin
      mfull[b] = 1'b0;
      mcnt[b]  = 0;
      mrel ^= 1;
    end
  endtask

  task automatic verify(int b, string req);
    for (int i = 0; i < mcnt[b]; i++) begin
      host_raddr = {1'(b), AW'(i)};
      @(negedge clk);
      chk(req, "read data", 64'(host_rdata), 64'(exp_mem[b][i]));
    end
  endtask

  task automatic fill_batch(int len, logic use_last);
    for (int i = 0; i < len; i++) begin
      if ($urandom % 4 == 0) @(negedge clk);
      send($urandom, use_last && (i == len - 1));
    end
  endtask

  initial begin
    #500000;
    misses++;
    $display("FAIL R1..all timeout actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [DW-1:0] sk0, sk1;
    void'($urandom(32'd12345));
    rst = 1'b1; s_valid = 1'b0; s_data = '0; s_last = 1'b0;
    host_raddr = '0; host_release = '0;
    mfull[0] = 0; mfull[1] = 0; mcnt[0] = 0; mcnt[1] = 0; mfill = 0; mrel = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_state("R8");

    // R2/R3: short tagged batch lands in buffer 0
    fill_batch(5, 1'b1);
    check_state("R3");
    chk("R2", "first batch in buffer 0", 64'(buf_full), 64'h1);
    // R6: release of an empty buffer is ignored
    rel(1);
    check_state("R6");

    // R4: fill buffer 1 to capacity, wait on the filling edge
    for (int i = 0; i < DEPTH - 1; i++) send($urandom, 1'b0);
    chk("R4", "wait before last slot", 64'(s_wait), 64'h0);
    send($urandom, 1'b0);
    chk("R4", "wait on filling edge", 64'(s_wait), 64'h1);
    check_state("R3");
    // R6: out-of-order release ignored
    rel(1);
    check_state("R6");

    // R5: two words pushed while waiting go into the skid store
    sk0 = $urandom; sk1 = $urandom;
    s_valid = 1'b1; s_data = sk0; @(negedge clk);
    s_data = sk1; @(negedge clk);
    s_valid = 1'b0;
    check_state("R9");
    verify(0, "R1 R9");
    rel(0);
    chk("R5", "wait held after release", 64'(s_wait), 64'h1);
    @(negedge clk);
    chk("R5", "wait held while draining", 64'(s_wait), 64'h1);
    @(negedge clk);
    chk("R5", "wait drops on last drain", 64'(s_wait), 64'h0);
    mput(sk0, 1'b0);
    mput(sk1, 1'b0);
    check_state("R5");
    verify(1, "R1");
    rel(1);
    check_state("R7");
    rel(1);
    check_state("R6");
    send($urandom, 1'b1);
    check_state("R2");
    verify(0, "R5");

    // random batches, released in fill order
    for (int r = 0; r < 12; r++) begin
      int  len;
      logic lst;
      if (mfull[mfill]) begin
        verify(mrel, "R1");
        rel(mrel);
        check_state("R6");
      end
      len = $urandom_range(1, DEPTH);
      lst = (len < DEPTH) ? 1'b1 : 1'($urandom % 2);
      fill_batch(len, lst);
      check_state("R3");
    end
    while (mfull[0] || mfull[1]) begin
      verify(mrel, "R2");
      rel(mrel);
      check_state("R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule